// File: doc/BRIEF.md
# Single-Operand Execute Unit with Condition Flags

This block is the purely combinational execute stage for one-operand integer operations on a word of `WIDTH` bits (16 by default). A 10-bit operation select, the old destination word and the incoming condition flags go in. The same cycle, out come the new destination word, a write-enable for that word, and the next set of flags. The flags are negative, zero, overflow and carry, packed as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C on both flag ports.

The unit covers clear, complement, increment, decrement, negate, add-carry, subtract-carry, test, the two rotates through carry, the two arithmetic shifts, sign extend and byte swap. Every operation has its own flag rule. A select that matches none of them passes the operand and flags through unchanged and raises `illegal`.

Top module: `unary_exec_unit`

## Requirements
- R1: Select 0050 (octal) clears: result 0, wr_en 1, flags NZVC = 0100 whatever the operand and incoming flags.
- R2: Select 0051 inverts every bit; N and Z follow the result, V = 0, C = 1.
- R3: Selects 0052 (add one) and 0053 (subtract one) keep the incoming C; N and Z follow the result. V is 1 only for the step from largest positive to most negative (add one) or from most negative to largest positive (subtract one).
- R4: Select 0054 gives the two's complement; C = 1 unless the result is 0, and V = 1 only when the operand is the most negative value, which maps to itself.
- R5: Select 0055 adds the incoming C and 0056 subtracts it. V flags a signed wrap and C flags an unsigned wrap across the all-ones/zero boundary; with C = 0 the word is unchanged.
- R6: Select 0057 leaves the word untouched, drives wr_en 0, sets N and Z from the operand and clears V and C.
- R7: Select 0060 rotates right through C (old C into the top bit, bit 0 into C); 0061 rotates left through C (old C into bit 0, top bit into C).
- R8: Select 0062 shifts right keeping the sign bit, with bit 0 into C; 0063 shifts left with 0 into bit 0 and the top bit into C. The incoming C is ignored.
- R9: After any of the four shifts/rotates, V equals N xor C of the new flags.
- R10: Select 0067 writes all ones when the incoming N is 1 and 0 otherwise; Z becomes the inverse of N, V = 0, N and C are kept.
- R11: Select 0003 exchanges the upper and lower halves of the word; N and Z come from the lower half of the result only, V = 0 and C = 0.
- R12: Any other select sets illegal = 1 and wr_en = 0, and returns the operand and flags unchanged.
- R13: For every recognised select other than 0057, wr_en is 1 and illegal is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 10 | Operation select (upper ten bits of the instruction word) |
| operand | input | WIDTH | Old destination word |
| flags_in | input | 4 | Incoming NZVC (bit 3 N .. bit 0 C) |
| result | output | WIDTH | New destination word |
| wr_en | output | 1 | Destination should be written |
| flags_out | output | 4 | Next NZVC (bit 3 N .. bit 0 C) |
| illegal | output | 1 | Select not recognised |

## Verification
The bench builds the unit at its default width of 16 bits, the width for which the octal boundary values (077777, 100000, 177777) and the half-word swap have their natural meaning. At that width every overflow and carry edge of increment, decrement, negate and the carry-adding operations can be hit with a handful of operands. The rotate and shift cases include both values of the incoming carry, so the paths that use C can be told apart from the ones that ignore it.

// File: rtl/unary_exec_pkg.sv
`timescale 1ns/1ps
package unary_exec_pkg;

    localparam int OPW = 10;

    // Operation select codes (upper ten bits of the instruction word)
    localparam logic [OPW-1:0] SEL_CLR  = 10'o050;
    localparam logic [OPW-1:0] SEL_COM  = 10'o051;
    localparam logic [OPW-1:0] SEL_INC  = 10'o052;
    localparam logic [OPW-1:0] SEL_DEC  = 10'o053;
    localparam logic [OPW-1:0] SEL_NEG  = 10'o054;
    localparam logic [OPW-1:0] SEL_ADC  = 10'o055;
    localparam logic [OPW-1:0] SEL_SBC  = 10'o056;
    localparam logic [OPW-1:0] SEL_TST  = 10'o057;
    localparam logic [OPW-1:0] SEL_ROR  = 10'o060;
    localparam logic [OPW-1:0] SEL_ROL  = 10'o061;
    localparam logic [OPW-1:0] SEL_ASR  = 10'o062;
    localparam logic [OPW-1:0] SEL_ASL  = 10'o063;
    localparam logic [OPW-1:0] SEL_SXT  = 10'o067;
    localparam logic [OPW-1:0] SEL_SWAB = 10'o003;

    typedef enum logic [3:0] {
        K_CLR, K_COM, K_INC, K_DEC, K_NEG, K_ADC, K_SBC, K_TST,
        K_ROR, K_ROL, K_ASR, K_ASL, K_SXT, K_SWAB, K_BAD
    } op_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

    function automatic op_kind_e decode_sel(input logic [OPW-1:0] s);
        op_kind_e k;
        case (s)
            SEL_CLR:  k = K_CLR;
            SEL_COM:  k = K_COM;
            SEL_INC:  k = K_INC;
            SEL_DEC:  k = K_DEC;
            SEL_NEG:  k = K_NEG;
            SEL_ADC:  k = K_ADC;
            SEL_SBC:  k = K_SBC;
            SEL_TST:  k = K_TST;
            SEL_ROR:  k = K_ROR;
            SEL_ROL:  k = K_ROL;
            SEL_ASR:  k = K_ASR;
            SEL_ASL:  k = K_ASL;
            SEL_SXT:  k = K_SXT;
            SEL_SWAB: k = K_SWAB;
            default:  k = K_BAD;
        endcase
        return k;
    endfunction

    function automatic logic is_shift(input op_kind_e k);
        return (k == K_ROR) || (k == K_ROL) || (k == K_ASR) || (k == K_ASL);
    endfunction

endpackage

// File: rtl/uxu_decode.sv
`timescale 1ns/1ps
module uxu_decode
    import unary_exec_pkg::*;
(
    input  logic [OPW-1:0] op_sel,
    output op_kind_e       kind,
    output logic           illegal,
    output logic           wr_en
);
    always_comb begin
        kind    = decode_sel(op_sel);
        illegal = (kind == K_BAD);
        wr_en   = !((kind == K_BAD) || (kind == K_TST));
    end
endmodule

// File: rtl/uxu_arith.sv
`timescale 1ns/1ps
module uxu_arith
    import unary_exec_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  op_kind_e         kind,
    input  logic [WIDTH-1:0] a,
    input  nzvc_t            fin,
    output logic [WIDTH-1:0] r,
    output nzvc_t            f
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ONES    = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO    = {WIDTH{1'b0}};
    localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] cin_w;
    assign cin_w = {{(WIDTH-1){1'b0}}, fin.c};

    always_comb begin
        r = a;
        f = fin;
        case (kind)
            K_CLR: begin
                r   = ZERO;
                f.v = 1'b0;
                f.c = 1'b0;
            end
            K_COM: begin
                r   = ~a;
                f.v = 1'b0;
                f.c = 1'b1;
            end
            K_INC: begin
                r   = a + ONE;
                f.v = (a == MAX_POS);
            end
            K_DEC: begin
                r   = a - ONE;
                f.v = (a == MIN_NEG);
            end
            K_NEG: begin
                r   = ZERO - a;
                f.v = (a == MIN_NEG);
                f.c = (a != ZERO);
            end
            K_ADC: begin
                r   = a + cin_w;
                f.v = fin.c && (a == MAX_POS);
                f.c = fin.c && (a == ONES);
            end
            K_SBC: begin
                r   = a - cin_w;
                f.v = fin.c && (a == MIN_NEG);
                f.c = fin.c && (a == ZERO);
            end
            K_TST: begin
                r   = a;
                f.v = 1'b0;
                f.c = 1'b0;
            end
            default: begin
                r = a;
                f = fin;
            end
        endcase
        f.n = r[MSB];
        f.z = (r == ZERO);
    end
endmodule

// File: rtl/uxu_shift.sv
`timescale 1ns/1ps
module uxu_shift
    import unary_exec_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  op_kind_e         kind,
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    output logic [WIDTH-1:0] r,
    output nzvc_t            f
);
    localparam int MSB = WIDTH - 1;

    logic cout;

    always_comb begin
        case (kind)
            K_ROR: begin
                r    = {cin, a[MSB:1]};
                cout = a[0];
            end
            K_ROL: begin
                r    = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            K_ASR: begin
                r    = {a[MSB], a[MSB:1]};
                cout = a[0];
            end
            K_ASL: begin
                r    = {a[MSB-1:0], 1'b0};
                cout = a[MSB];
            end
            default: begin
                r    = a;
                cout = cin;
            end
        endcase
        f.n = r[MSB];
        f.z = (r == '0);
        f.c = cout;
        f.v = r[MSB] ^ cout;
    end
endmodule

// File: rtl/uxu_misc.sv
`timescale 1ns/1ps
module uxu_misc
    import unary_exec_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  op_kind_e         kind,
    input  logic [WIDTH-1:0] a,
    input  nzvc_t            fin,
    output logic [WIDTH-1:0] r,
    output nzvc_t            f
);
    localparam int HALF = WIDTH / 2;

    always_comb begin
        r = a;
        f = fin;
        if (kind == K_SXT) begin
            r   = {WIDTH{fin.n}};
            f.z = !fin.n;
            f.v = 1'b0;
        end else if (kind == K_SWAB) begin
            r   = {a[HALF-1:0], a[WIDTH-1:HALF]};
            f.n = a[WIDTH-1];
            f.z = (a[WIDTH-1:HALF] == '0);
            f.v = 1'b0;
            f.c = 1'b0;
        end
    end
endmodule

// File: rtl/unary_exec_unit.sv
`timescale 1ns/1ps
module unary_exec_unit
    import unary_exec_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [9:0]       op_sel,
    input  logic [WIDTH-1:0] operand,
    input  logic [3:0]       flags_in,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic [3:0]       flags_out,
    output logic             illegal
);
    op_kind_e         kind;
    nzvc_t            fin;
    logic [WIDTH-1:0] r_arith, r_shift, r_misc;
    nzvc_t            f_arith, f_shift, f_misc;

    assign fin = nzvc_t'(flags_in);

    uxu_decode u_decode (
        .op_sel  (op_sel),
        .kind    (kind),
        .illegal (illegal),
        .wr_en   (wr_en)
    );

    uxu_arith #(.WIDTH(WIDTH)) u_arith (
        .kind (kind),
        .a    (operand),
        .fin  (fin),
        .r    (r_arith),
        .f    (f_arith)
    );

    uxu_shift #(.WIDTH(WIDTH)) u_shift (
        .kind (kind),
        .a    (operand),
        .cin  (fin.c),
        .r    (r_shift),
        .f    (f_shift)
    );

    uxu_misc #(.WIDTH(WIDTH)) u_misc (
        .kind (kind),
        .a    (operand),
        .fin  (fin),
        .r    (r_misc),
        .f    (f_misc)
    );

    always_comb begin
        if (kind == K_BAD) begin
            result    = operand;
            flags_out = flags_in;
        end else if (is_shift(kind)) begin
            result    = r_shift;
            flags_out = f_shift;
        end else if ((kind == K_SXT) || (kind == K_SWAB)) begin
            result    = r_misc;
            flags_out = f_misc;
        end else begin
            result    = r_arith;
            flags_out = f_arith;
        end
    end
endmodule

// File: rtl/unary_exec_unit_chk.sv
`timescale 1ns/1ps
module unary_exec_unit_chk
    import unary_exec_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic [9:0]       op_sel,
    input logic [WIDTH-1:0] operand,
    input logic [3:0]       flags_in,
    input logic [WIDTH-1:0] result,
    input logic             wr_en,
    input logic [3:0]       flags_out,
    input logic             illegal
);
    logic shift_sel;
    assign shift_sel = (op_sel == SEL_ROR) || (op_sel == SEL_ROL) ||
                       (op_sel == SEL_ASR) || (op_sel == SEL_ASL);

    always_comb begin
        if (op_sel == SEL_CLR)
            assert_clr_zero_R1: assert (result == '0 && flags_out == 4'b0100 && wr_en);
        if (op_sel == SEL_COM)
            assert_com_carry_R2: assert (flags_out[0] && !flags_out[1]);
        if (op_sel == SEL_INC || op_sel == SEL_DEC)
            assert_step_keeps_c_R3: assert (flags_out[0] == flags_in[0]);
        if (op_sel == SEL_TST)
            assert_tst_nowrite_R6: assert (!wr_en && result == operand && flags_out[1:0] == 2'b00);
        if (shift_sel)
            assert_shift_v_rule_R9: assert (flags_out[1] == (flags_out[3] ^ flags_out[0]));
        if (op_sel == SEL_SXT)
            assert_sxt_keeps_nc_R10: assert (flags_out[3] == flags_in[3] && flags_out[0] == flags_in[0]);
        if (op_sel == SEL_SWAB)
            assert_swab_clears_vc_R11: assert (flags_out[1:0] == 2'b00);
        if (illegal)
            assert_illegal_passthru_R12: assert (!wr_en && result == operand && flags_out == flags_in);
    end
endmodule

bind unary_exec_unit unary_exec_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .op_sel    (op_sel),
    .operand   (operand),
    .flags_in  (flags_in),
    .result    (result),
    .wr_en     (wr_en),
    .flags_out (flags_out),
    .illegal   (illegal)
);

// File: tb/unary_exec_unit_tb.sv
`timescale 1ns/1ps
module unary_exec_unit_tb;
    localparam int WIDTH = 16;
    localparam int NV    = 37;

    logic             clk = 1'b0;
    logic [9:0]       op_sel = '0;
    logic [WIDTH-1:0] operand = '0;
    logic [3:0]       flags_in = '0;
    logic [WIDTH-1:0] result;
    logic             wr_en;
    logic [3:0]       flags_out;
    logic             illegal;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    unary_exec_unit #(.WIDTH(WIDTH)) u_dut (
        .op_sel    (op_sel),
        .operand   (operand),
        .flags_in  (flags_in),
        .result    (result),
        .wr_en     (wr_en),
        .flags_out (flags_out),
        .illegal   (illegal)
    );

    // {req, select, operand, flags in, exp result, exp flags, exp wr_en, exp illegal}
    typedef logic [55:0] vec_t;
    localparam vec_t VEC [NV] = '{
        {4'd1,  10'o050, 16'o177777, 4'b0000, 16'o000000, 4'b0100, 1'b1, 1'b0}, // R1
        {4'd1,  10'o050, 16'o000001, 4'b1111, 16'o000000, 4'b0100, 1'b1, 1'b0}, // R1
        {4'd2,  10'o051, 16'o000000, 4'b0000, 16'o177777, 4'b1001, 1'b1, 1'b0}, // R2
        {4'd2,  10'o051, 16'o100000, 4'b1111, 16'o077777, 4'b0001, 1'b1, 1'b0}, // R2
        {4'd2,  10'o051, 16'o177777, 4'b0000, 16'o000000, 4'b0101, 1'b1, 1'b0}, // R2
        {4'd3,  10'o052, 16'o077777, 4'b0000, 16'o100000, 4'b1010, 1'b1, 1'b0}, // R3
        {4'd3,  10'o052, 16'o177777, 4'b0001, 16'o000000, 4'b0101, 1'b1, 1'b0}, // R3
        {4'd3,  10'o052, 16'o000001, 4'b0001, 16'o000002, 4'b0001, 1'b1, 1'b0}, // R3
        {4'd3,  10'o053, 16'o100000, 4'b0000, 16'o077777, 4'b0010, 1'b1, 1'b0}, // R3
        {4'd3,  10'o053, 16'o000001, 4'b0001, 16'o000000, 4'b0101, 1'b1, 1'b0}, // R3
        {4'd3,  10'o053, 16'o000000, 4'b0000, 16'o177777, 4'b1000, 1'b1, 1'b0}, // R3
        {4'd4,  10'o054, 16'o000000, 4'b1111, 16'o000000, 4'b0100, 1'b1, 1'b0}, // R4
        {4'd4,  10'o054, 16'o000001, 4'b0000, 16'o177777, 4'b1001, 1'b1, 1'b0}, // R4
        {4'd4,  10'o054, 16'o100000, 4'b0000, 16'o100000, 4'b1011, 1'b1, 1'b0}, // R4
        {4'd4,  10'o054, 16'o177777, 4'b0000, 16'o000001, 4'b0001, 1'b1, 1'b0}, // R4
        {4'd5,  10'o055, 16'o077777, 4'b0001, 16'o100000, 4'b1010, 1'b1, 1'b0}, // R5
        {4'd5,  10'o055, 16'o177777, 4'b0001, 16'o000000, 4'b0101, 1'b1, 1'b0}, // R5
        {4'd5,  10'o055, 16'o177777, 4'b0000, 16'o177777, 4'b1000, 1'b1, 1'b0}, // R5
        {4'd5,  10'o056, 16'o000000, 4'b0001, 16'o177777, 4'b1001, 1'b1, 1'b0}, // R5
        {4'd5,  10'o056, 16'o100000, 4'b0001, 16'o077777, 4'b0010, 1'b1, 1'b0}, // R5
        {4'd5,  10'o056, 16'o000001, 4'b0001, 16'o000000, 4'b0100, 1'b1, 1'b0}, // R5
        {4'd6,  10'o057, 16'o100000, 4'b0111, 16'o100000, 4'b1000, 1'b0, 1'b0}, // R6
        {4'd6,  10'o057, 16'o000000, 4'b1011, 16'o000000, 4'b0100, 1'b0, 1'b0}, // R6
        {4'd9,  10'o060, 16'o000001, 4'b0000, 16'o000000, 4'b0111, 1'b1, 1'b0}, // R9
        {4'd7,  10'o060, 16'o000000, 4'b0001, 16'o100000, 4'b1010, 1'b1, 1'b0}, // R7
        {4'd7,  10'o061, 16'o100000, 4'b0000, 16'o000000, 4'b0111, 1'b1, 1'b0}, // R7
        {4'd7,  10'o061, 16'o040100, 4'b0001, 16'o100201, 4'b1010, 1'b1, 1'b0}, // R7
        {4'd8,  10'o062, 16'o100000, 4'b0000, 16'o140000, 4'b1010, 1'b1, 1'b0}, // R8
        {4'd9,  10'o062, 16'o000101, 4'b0000, 16'o000040, 4'b0011, 1'b1, 1'b0}, // R9
        {4'd8,  10'o063, 16'o100100, 4'b0000, 16'o000200, 4'b0011, 1'b1, 1'b0}, // R8
        {4'd8,  10'o063, 16'o040100, 4'b0001, 16'o100200, 4'b1010, 1'b1, 1'b0}, // R8
        {4'd10, 10'o067, 16'o012345, 4'b1000, 16'o177777, 4'b1000, 1'b1, 1'b0}, // R10
        {4'd10, 10'o067, 16'o012345, 4'b0111, 16'o000000, 4'b0101, 1'b1, 1'b0}, // R10
        {4'd11, 10'o003, 16'o000200, 4'b0000, 16'o100000, 4'b0100, 1'b1, 1'b0}, // R11
        {4'd11, 10'o003, 16'o100001, 4'b1111, 16'o000600, 4'b1000, 1'b1, 1'b0}, // R11
        {4'd12, 10'o064, 16'o123456, 4'b1010, 16'o123456, 4'b1010, 1'b0, 1'b1}, // R12
        {4'd12, 10'o000, 16'o000000, 4'b0101, 16'o000000, 4'b0101, 1'b0, 1'b1}  // R12
    };

    task automatic apply(input logic [9:0] s, input logic [WIDTH-1:0] a, input logic [3:0] f);
        @(negedge clk);
        op_sel   = s;
        operand  = a;
        flags_in = f;
        #2;
    endtask

    task automatic check(input string req, input logic [WIDTH-1:0] er, input logic [3:0] ef,
                         input logic ew, input logic ei);
        checks++;
        if (result !== er || flags_out !== ef || wr_en !== ew || illegal !== ei) begin
            fails++;
            $display("FAIL %s sel=%o opnd=%o: got res=%o nzvc=%b we=%b ill=%b, expected res=%o nzvc=%b we=%b ill=%b",
                     req, op_sel, operand, result, flags_out, wr_en, illegal, er, ef, ew, ei);
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        // Idle state: all-zero select is unrecognised (R12)
        #2;
        check("R12", 16'o0, 4'b0000, 1'b0, 1'b1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VEC[i];
            apply(v[51:42], v[41:26], v[25:22]);
            tag = $sformatf("R%0d", v[55:52]);
            check(tag, v[21:6], v[5:2], v[1], v[0]);
        end

        // R13: every recognised select except test writes and is legal
        begin
            logic [9:0] codes [14] = '{10'o050, 10'o051, 10'o052, 10'o053, 10'o054, 10'o055,
                                        10'o056, 10'o057, 10'o060, 10'o061, 10'o062, 10'o063,
                                        10'o067, 10'o003};
            for (int k = 0; k < 14; k++) begin
                apply(codes[k], 16'o052525, 4'b0000);
                checks++;
                if (wr_en !== (codes[k] != 10'o057) || illegal !== 1'b0) begin
                    fails++;
                    $display("FAIL R13 sel=%o: got we=%b ill=%b, expected we=%b ill=0",
                             codes[k], wr_en, illegal, (codes[k] != 10'o057));
                end
            end
        end

        // R3: step operations over a spread of operands, carry kept both ways
        for (int j = 0; j < 8; j++) begin
            logic [WIDTH-1:0] a;
            logic [WIDTH-1:0] e;
            logic c;
            a = 16'(j * 16'o010101 + 3);
            c = j[0];
            e = a + 16'd1;
            apply(10'o052, a, {3'b000, c});
            check("R3", e, {e[15], e == 0, a == 16'o077777, c}, 1'b1, 1'b0);
            e = a - 16'd1;
            apply(10'o053, a, {3'b111, c});
            check("R3", e, {e[15], e == 0, a == 16'o100000, c}, 1'b1, 1'b0);
        end

        // R8: arithmetic shift right of all-ones keeps sign, C from bit 0
        apply(10'o062, 16'o177777, 4'b0000);
        check("R8", 16'o177777, 4'b1001, 1'b1, 1'b0);

        // R12: unused code next to swab leaves everything untouched
        apply(10'o004, 16'o177400, 4'b1111);
        check("R12", 16'o177400, 4'b1111, 1'b0, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule